// File: doc/BRIEF.md
# Monotonic Lifecycle State Controller

This block holds the device's lifecycle level and turns it into the policy enables that the rest of the chip obeys. There are four ordered levels: factory, development, deployed and retired. The level is held in a small model of one-time-programmable fuse bits that can only ever be set, never cleared. The fuses use a thermometer code, so each advance only adds set bits and no earlier level can be reached again.

Software, or the security processor, asks for a new level by giving a target and an authorization-valid flag. The flag stands for a signature check done elsewhere. A request is accepted only if the target is exactly the next level up and, where the target needs it, the flag is set. An accepted request runs a fixed program operation and then reports done. A rejected request reports an error code at once. Retirement raises a one-cycle wipe request for owner keys and certificates, and it blocks the start of application cores for good.

Top module: `lifecycle_ctrl`

## Requirements
- R1: `state_o` reports the level as 0 factory, 1 development, 2 deployed, 3 retired. The fuse pattern for level n has its n low bits set (000, 001, 011, 111). After reset the level is the one given by `FUSE_INIT`, which is 0 by default.
- R2: A request whose target is at or below the current level is rejected with code 1 (backward). The level does not change.
- R3: A request whose target is more than one level above the current level is rejected with code 2 (skip). The level does not change.
- R4: A request to level 3 with `auth_valid_i` low is rejected with code 3 (unauthorized). With `auth_valid_i` high the request is accepted. By default the lower levels need no authorization.
- R5: An accepted request, sampled at clock edge E0, holds `busy_o` high during the four cycles that follow. At edge E0+4 `busy_o` falls, `state_o` takes the new level and `done_o` is high for exactly that one cycle.
- R6: A request that arrives while `busy_o` is high is rejected with code 4 (busy). It does not change the level that the running operation writes.
- R7: A rejection drives `err_o` high with `err_code_o` in the cycle after the request edge, for exactly one cycle. `err_code_o` is 0 whenever `err_o` is low.
- R8: In levels 0 and 1, debug, programming and firewall-open are all high, secure-boot-required and signed-updates-only are low, and boot is allowed. Keys-valid is high only in level 1.
- R9: In level 2, firewall-open and programming are low, secure boot, signed-updates-only, keys-valid and boot-allowed are high, and `dbg_en_o` follows `owner_dbg_en_i`.
- R10: In level 3, debug, programming, firewall-open, keys-valid and boot-allowed are all low. `wipe_req_o` is high for exactly the one cycle in which the level becomes 3. Any fuse pattern that is not a valid thermometer code is read as level 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (models power-up fuse load) |
| req_valid_i | input | 1 | Advance request strobe |
| req_target_i | input | 2 | Requested level |
| auth_valid_i | input | 1 | Authorization for the request has been verified |
| owner_dbg_en_i | input | 1 | Owner permits debug in the deployed level |
| busy_o | output | 1 | Fuse program operation in progress |
| done_o | output | 1 | One-cycle pulse: advance completed |
| err_o | output | 1 | One-cycle pulse: request rejected |
| err_code_o | output | 3 | Rejection reason: 1 backward, 2 skip, 3 unauthorized, 4 busy |
| state_o | output | 2 | Current level |
| dbg_en_o | output | 1 | Debug access enabled |
| prog_en_o | output | 1 | Device programming enabled |
| fw_open_o | output | 1 | Firewalls open |
| sboot_req_o | output | 1 | Secure boot required |
| signed_only_o | output | 1 | Only signed updates accepted |
| keys_valid_o | output | 1 | Owner keys usable |
| boot_allow_o | output | 1 | Application cores may be started |
| wipe_req_o | output | 1 | One-cycle pulse requesting key and certificate wipe |

## Verification
The properties assume that the fuse bits start from a valid thermometer pattern and change only through the program path. They also assume that a reset returns only the power-up pattern and is not used in the middle of a test to roll the level back. Under these assumptions, level steps of exactly +1 and busy windows of at most four cycles are always true. The stimulus pulses reset only at the start of each directed scenario. It places the second request of the busy test inside the program window, and it drives the invalid fuse pattern only through a separate instance built with a bad initial value, so the main instance never sees it.

// File: rtl/lcs_pkg.sv
`timescale 1ns/1ps
package lcs_pkg;
  localparam int NUM_ST = 4;
  localparam int ST_W   = $clog2(NUM_ST);
  localparam int FUSE_W = NUM_ST - 1;

  typedef enum logic [ST_W-1:0] {
    ST_FACT = 2'd0,
    ST_DEV  = 2'd1,
    ST_DEPL = 2'd2,
    ST_RET  = 2'd3
  } lcs_e;

  typedef enum logic [2:0] {
    E_NONE  = 3'd0,
    E_BACK  = 3'd1,
    E_SKIP  = 3'd2,
    E_AUTH  = 3'd3,
    E_BUSY  = 3'd4
  } err_e;

  typedef struct packed {
    logic dbg;
    logic prog;
    logic fw_open;
    logic sboot;
    logic signed_only;
    logic keys;
    logic boot;
  } policy_t;

  function automatic logic [FUSE_W-1:0] therm(input logic [ST_W-1:0] lvl);
    logic [FUSE_W-1:0] r;
    r = '0;
    for (int i = 0; i < FUSE_W; i++) r[i] = (ST_W'(i) < lvl);
    return r;
  endfunction
endpackage

// File: rtl/lcs_fuse_bank.sv
`timescale 1ns/1ps
module lcs_fuse_bank
  import lcs_pkg::*;
#(
  parameter logic [FUSE_W-1:0] FUSE_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic [FUSE_W-1:0] prog_mask_i,
  output lcs_e              state_o
);
  logic [FUSE_W-1:0] fuse_q;
  logic [NUM_ST-1:0] hit;

  // set-only: programming can never clear a bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fuse_q <= FUSE_INIT;
    else if (prog_i) fuse_q <= fuse_q | prog_mask_i;
  end

  for (genvar g = 0; g < NUM_ST; g++) begin : g_dec
    assign hit[g] = (fuse_q == therm(ST_W'(g)));
  end

  // invalid pattern falls through to retired
  always_comb begin
    state_o = ST_RET;
    for (int i = 0; i < NUM_ST; i++)
      if (hit[i]) state_o = lcs_e'(i);
  end
endmodule

// File: rtl/lcs_policy.sv
`timescale 1ns/1ps
module lcs_policy
  import lcs_pkg::*;
(
  input  lcs_e    state_i,
  input  logic    owner_dbg_en_i,
  output policy_t pol_o
);
  always_comb begin
    pol_o = '0;
    unique case (state_i)
      ST_FACT: begin
        pol_o.dbg = 1'b1; pol_o.prog = 1'b1; pol_o.fw_open = 1'b1;
        pol_o.boot = 1'b1;
      end
      ST_DEV: begin
        pol_o.dbg = 1'b1; pol_o.prog = 1'b1; pol_o.fw_open = 1'b1;
        pol_o.keys = 1'b1; pol_o.boot = 1'b1;
      end
      ST_DEPL: begin
        pol_o.dbg = owner_dbg_en_i; pol_o.sboot = 1'b1;
        pol_o.signed_only = 1'b1; pol_o.keys = 1'b1; pol_o.boot = 1'b1;
      end
      default: begin
        pol_o.sboot = 1'b1; pol_o.signed_only = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/lcs_seq.sv
`timescale 1ns/1ps
module lcs_seq
  import lcs_pkg::*;
#(
  parameter int                PROG_CYC  = 4,
  parameter logic [NUM_ST-1:0] AUTH_MASK = 4'b1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ST_W-1:0]   req_target_i,
  input  logic              auth_valid_i,
  input  lcs_e              state_i,
  output logic              prog_o,
  output logic [FUSE_W-1:0] prog_mask_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output err_e              err_code_o,
  output logic              wipe_o
);
  localparam int CNT_W = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYC - 1);

  logic              busy_q, done_q, err_q, wipe_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ST_W-1:0]   tgt_q;
  err_e              code_q, chk_code;
  logic [ST_W:0]     nxt_lvl;

  assign nxt_lvl = {1'b0, state_i} + 1'b1;

  always_comb begin
    if (busy_q)                                         chk_code = E_BUSY;
    else if (req_target_i <= state_i)                   chk_code = E_BACK;
    else if ({1'b0, req_target_i} != nxt_lvl)           chk_code = E_SKIP;
    else if (AUTH_MASK[req_target_i] && !auth_valid_i)  chk_code = E_AUTH;
    else                                                chk_code = E_NONE;
  end

  assign prog_o      = busy_q && (cnt_q == CNT_LAST);
  assign prog_mask_o = therm(tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      wipe_q <= 1'b0;
      cnt_q  <= '0;
      tgt_q  <= '0;
      code_q <= E_NONE;
    end else begin
      done_q <= 1'b0;
      wipe_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= E_NONE;
      if (busy_q) begin
        if (cnt_q == CNT_LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          wipe_q <= (tgt_q == ST_RET);
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (req_valid_i) begin
        if (chk_code == E_NONE) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          tgt_q  <= req_target_i;
        end else begin
          err_q  <= 1'b1;
          code_q <= chk_code;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;
  assign wipe_o     = wipe_q;
endmodule

// File: rtl/lifecycle_ctrl.sv
`timescale 1ns/1ps
module lifecycle_ctrl
  import lcs_pkg::*;
#(
  parameter int                PROG_CYC  = 4,
  parameter logic [FUSE_W-1:0] FUSE_INIT = '0,
  parameter logic [NUM_ST-1:0] AUTH_MASK = 4'b1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [ST_W-1:0]  req_target_i,
  input  logic             auth_valid_i,
  input  logic             owner_dbg_en_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       err_code_o,
  output logic [ST_W-1:0]  state_o,
  output logic             dbg_en_o,
  output logic             prog_en_o,
  output logic             fw_open_o,
  output logic             sboot_req_o,
  output logic             signed_only_o,
  output logic             keys_valid_o,
  output logic             boot_allow_o,
  output logic             wipe_req_o
);
  lcs_e              cur_st;
  logic              prog;
  logic [FUSE_W-1:0] prog_mask;
  err_e              code;
  policy_t           pol;

  lcs_fuse_bank #(.FUSE_INIT(FUSE_INIT)) u_fuse (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prog_i      (prog),
    .prog_mask_i (prog_mask),
    .state_o     (cur_st)
  );

  lcs_seq #(.PROG_CYC(PROG_CYC), .AUTH_MASK(AUTH_MASK)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_target_i (req_target_i),
    .auth_valid_i (auth_valid_i),
    .state_i      (cur_st),
    .prog_o       (prog),
    .prog_mask_o  (prog_mask),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .err_code_o   (code),
    .wipe_o       (wipe_req_o)
  );

  lcs_policy u_pol (
    .state_i        (cur_st),
    .owner_dbg_en_i (owner_dbg_en_i),
    .pol_o          (pol)
  );

  assign err_code_o    = code;
  assign state_o       = cur_st;
  assign dbg_en_o      = pol.dbg;
  assign prog_en_o     = pol.prog;
  assign fw_open_o     = pol.fw_open;
  assign sboot_req_o   = pol.sboot;
  assign signed_only_o = pol.signed_only;
  assign keys_valid_o  = pol.keys;
  assign boot_allow_o  = pol.boot;
endmodule

// File: rtl/lcs_chk.sv
`timescale 1ns/1ps
module lcs_chk #(
  parameter int PROG_CYC = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic [2:0] err_code_o,
  input logic [1:0] state_o,
  input logic       dbg_en_o,
  input logic       prog_en_o,
  input logic       fw_open_o,
  input logic       keys_valid_o,
  input logic       boot_allow_o,
  input logic       wipe_req_o
);
  int unsigned busy_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run <= 0;
    else if (busy_o) busy_run <= busy_run + 1;
    else             busy_run <= 0;
  end

  a_r2_no_backward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o >= $past(state_o));
  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != $past(state_o)) |-> (state_o == $past(state_o) + 2'd1));
  a_r5_busy_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= PROG_CYC);
  a_r5_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r6_busy_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && busy_o) |=> (err_o && err_code_o == 3'd4));
  a_r7_code_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o |-> (err_code_o == 3'd0));
  a_r8_dev_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1) |-> (dbg_en_o && prog_en_o && fw_open_o));
  a_r10_retired_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3) |-> !(boot_allow_o || keys_valid_o || dbg_en_o || fw_open_o));
  a_r10_wipe_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_req_o |-> (done_o && state_o == 2'd3 && $past(state_o) == 2'd2));
endmodule

bind lifecycle_ctrl lcs_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .err_code_o   (err_code_o),
  .state_o      (state_o),
  .dbg_en_o     (dbg_en_o),
  .prog_en_o    (prog_en_o),
  .fw_open_o    (fw_open_o),
  .keys_valid_o (keys_valid_o),
  .boot_allow_o (boot_allow_o),
  .wipe_req_o   (wipe_req_o)
);

// File: tb/lifecycle_ctrl_test.sv
`timescale 1ns/1ps
module lifecycle_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_v = 1'b0;
  logic [1:0] req_t = 2'd0;
  logic auth = 1'b0;
  logic odbg = 1'b0;
  logic busy, done, err, dbg, prg, fwo, sbt, sgn, keys, boot, wipe;
  logic [2:0] code;
  logic [1:0] st;
  logic b_busy, b_done, b_err, b_dbg, b_prg, b_fwo, b_sbt, b_sgn, b_keys, b_boot, b_wipe;
  logic [2:0] b_code;
  logic [1:0] b_st;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  lifecycle_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_target_i(req_t),
    .auth_valid_i(auth), .owner_dbg_en_i(odbg), .busy_o(busy), .done_o(done),
    .err_o(err), .err_code_o(code), .state_o(st), .dbg_en_o(dbg),
    .prog_en_o(prg), .fw_open_o(fwo), .sboot_req_o(sbt), .signed_only_o(sgn),
    .keys_valid_o(keys), .boot_allow_o(boot), .wipe_req_o(wipe));

  lifecycle_ctrl #(.FUSE_INIT(3'b010)) uut_bad (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(1'b0), .req_target_i(2'd0),
    .auth_valid_i(1'b0), .owner_dbg_en_i(1'b1), .busy_o(b_busy), .done_o(b_done),
    .err_o(b_err), .err_code_o(b_code), .state_o(b_st), .dbg_en_o(b_dbg),
    .prog_en_o(b_prg), .fw_open_o(b_fwo), .sboot_req_o(b_sbt), .signed_only_o(b_sgn),
    .keys_valid_o(b_keys), .boot_allow_o(b_boot), .wipe_req_o(b_wipe));

  // {target[1:0], auth, code[2:0], state_after[1:0]}; code 0 = accepted
  localparam logic [7:0] VEC [10] = '{
    {2'd0, 1'b0, 3'd1, 2'd0},
    {2'd2, 1'b1, 3'd2, 2'd0},
    {2'd1, 1'b0, 3'd0, 2'd1},
    {2'd0, 1'b1, 3'd1, 2'd1},
    {2'd3, 1'b1, 3'd2, 2'd1},
    {2'd2, 1'b0, 3'd0, 2'd2},
    {2'd1, 1'b1, 3'd1, 2'd2},
    {2'd3, 1'b0, 3'd3, 2'd2},
    {2'd3, 1'b1, 3'd0, 2'd3},
    {2'd3, 1'b1, 3'd1, 2'd3}
  };

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // expected policy vector {dbg,prog,fw,sboot,signed,keys,boot}
  function automatic logic [6:0] exp_pol(input logic [1:0] s, input logic od);
    case (s)
      2'd0:    return 7'b1110001;
      2'd1:    return 7'b1110011;
      2'd2:    return {od, 6'b001111};
      default: return 7'b0001100;
    endcase
  endfunction

  task automatic chk_pol(input string rq);
    logic [6:0] a, e;
    a = {dbg, prg, fwo, sbt, sgn, keys, boot};
    e = exp_pol(st, odbg);
    chk(a == e, rq, a, e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_v = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic advance(input logic [1:0] t);
    req_t = t; auth = 1'b1; req_v = 1'b1;
    @(negedge clk); req_v = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset level, R8 factory policy
    chk(st == 2'd0, "R1 reset level", st, 0);
    chk(!busy && !done && !err && !wipe, "R1 reset status", {busy, done, err, wipe}, 0);
    chk_pol("R8 factory policy");
    // R10 invalid fuse pattern reads as retired
    chk(b_st == 2'd3, "R10 invalid pattern level", b_st, 3);
    chk(!b_boot && !b_dbg && !b_keys, "R10 invalid pattern policy", {b_boot, b_dbg, b_keys}, 0);

    // table walk: R2 R3 R4 R5 R7 R8 R9 R10
    foreach (VEC[i]) begin
      logic [1:0] t; logic a; logic [2:0] ec; logic [1:0] es;
      {t, a, ec, es} = VEC[i];
      req_t = t; auth = a; req_v = 1'b1;
      @(negedge clk); req_v = 1'b0;
      if (ec != 3'd0) begin
        chk(err && code == ec, "R2/R3/R4 reject code", code, ec);
        chk(!busy && !done, "R7 no busy on reject", busy, 0);
        @(negedge clk);
        chk(!err && code == 3'd0, "R7 single cycle error", err, 0);
      end else begin
        chk(busy && !err, "R5 busy after accept", busy, 1);
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(busy && !done && st != es, "R5 busy window", busy, 1);
        end
        @(negedge clk);
        chk(done && !busy, "R5 done pulse", done, 1);
        chk(wipe == (es == 2'd3), "R10 wipe on retire", wipe, es == 2'd3);
        @(negedge clk);
        chk(!done && !wipe, "R10 wipe one cycle", {done, wipe}, 0);
      end
      chk(st == es, "R2/R3 level after request", st, es);
      chk_pol("R8/R9/R10 policy");
    end

    // R6 busy rejection without side effect
    do_reset();
    req_t = 2'd1; auth = 1'b0; req_v = 1'b1;
    @(negedge clk);
    req_t = 2'd2; auth = 1'b1;
    @(negedge clk); req_v = 1'b0;
    chk(err && code == 3'd4, "R6 busy reject code", code, 4);
    chk(busy, "R6 program continues", busy, 1);
    repeat (3) @(negedge clk);
    chk(done && st == 2'd1, "R6 level written by first request", st, 1);

    // R9 owner debug follows input in deployed
    advance(2'd2);
    chk(st == 2'd2, "R9 reached deployed", st, 2);
    odbg = 1'b0; #1;
    chk(!dbg, "R9 owner debug off", dbg, 0);
    chk_pol("R9 deployed policy");
    odbg = 1'b1; #1;
    chk(dbg, "R9 owner debug on", dbg, 1);
    chk_pol("R9 deployed policy dbg on");

    // R4 default: deployed step needed no auth above; retire needs it
    req_t = 2'd3; auth = 1'b0; req_v = 1'b1;
    @(negedge clk); req_v = 1'b0;
    chk(err && code == 3'd3, "R4 unauthorized retire", code, 3);
    repeat (5) @(negedge clk);
    chk(st == 2'd2 && boot, "R4 level kept", st, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule